// File: doc/BRIEF.md
# Banked interrupt trigger router

This block gathers peripheral interrupt lines, arranged as one to four banks of 32, and turns them into a few active-low trigger lines, one per hardware thread. Each line passes through a synchroniser before anything else sees it. Each line then has three settings: a pending bit, a sensitivity bit that selects edge or level, and a pass bit. Each line also has a small routing code that picks the thread trigger it drives. A trigger stays low for as long as at least one line routed to it is both pending and passed.

Software reaches the block through a single-cycle register port. Writes take effect at the clock edge. Read data is combinational on the cycle that the read strobe is high. A 1 written to a pending bit inverts it, so the same write can clear a serviced edge or replay an interrupt. The pass bits are changed by writing a whole bank word back after a read.

Top module: `irq_trig_router`

## Requirements
- R1: Interrupt n is bit n mod 32 of bank n/32. The bank words are at 0x000+8*b (pending), 0x100+8*b (sensitivity) and 0x200+8*b (pass). The routing code of bank b, bit o is at 0x1000*(b+1)+8*o. Address bits [2:0] are ignored. Every other address, including any bank at or above NUM_BANKS, reads as 0, and writes to it change nothing.
- R2: After reset, all pending, sensitivity, pass and routing state is 0, and every trigger output is high.
- R3: A sensitivity or pass bank word reads back exactly the last 32-bit value written to it.
- R4: With sensitivity 0 (edge), a rising edge of the synchronised input sets the pending bit three clock edges after the input changes. The bit stays set after the input falls.
- R5: With sensitivity 1 (level), the pending bit is 1 while the synchronised input is high. It clears on the edge at which the synchronised input falls, three clock edges after the input drops.
- R6: Writing the pending word inverts each bit written as 1 and leaves each bit written as 0 unchanged. In edge mode, a rising edge in the same cycle as an inverting write leaves the bit at 1. In level mode, an input that is high keeps the bit at 1.
- R7: A routing code is 4 bits and reads back in bits [3:0], with the upper bits 0. Code t+1 routes the line to thread t. Code 0, or any code above NUM_THREADS, routes it nowhere.
- R8: trigN[t] is low exactly when some line is pending, passed and routed to thread t. It follows the register state in the same cycle, with no added register stage.
- R9: A pass bit of 0 keeps its line off every trigger, while the pending bit is still recorded and readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_BANKS*32 | Asynchronous peripheral interrupt lines |
| busRead | input | 1 | Read strobe; read data valid in the same cycle |
| busWrite | input | 1 | Write strobe; takes effect at the clock edge |
| busAddr | input | 16 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, 0 when no read or unmapped |
| trigN | output | NUM_THREADS | Active-low per-thread trigger |

## Verification
The case that needs care is a software write to the pending word landing on the same clock edge as a synchronised input transition for the same bit. It is provoked by setting an edge line's pending bit through software first. The line is then raised, and an inverting write is timed to land on exactly the third following edge. The bit must stay at 1 because the new edge outranks the clear. A long random phase also mixes writes with line toggles, and a behavioural model in the bench judges every cycle's trigger outputs and read data.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int WORD_W  = 32;
  localparam int BANK_SZ = 32;
  localparam int VEC_W   = 4;
  localparam int ADDR_W  = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_SENSE,
    SEL_ENABLE,
    SEL_VECTOR
  } regSel_e;

  // Strobes from address decode to the register datapath
  typedef struct packed {
    regSel_e    sel;
    logic       wr;
    logic [1:0] bank;
    logic [4:0] slot;
  } busCmd_t;
endpackage

// File: rtl/irq_trig_decode.sv
module irq_trig_decode
  import irq_trig_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busCmd_t           cmd
);
  logic [3:0] region;
  assign region = busAddr[15:12];

  always_comb begin
    cmd      = '0;
    cmd.sel  = SEL_NONE;
    cmd.wr   = busWrite;
    if (region == 4'd0) begin
      cmd.bank = busAddr[4:3];
      if (busAddr[11:10] == 2'b00 && busAddr[7:5] == 3'b000 &&
          int'(busAddr[4:3]) < NUM_BANKS) begin
        case (busAddr[9:8])
          2'd0:    cmd.sel = SEL_STATUS;
          2'd1:    cmd.sel = SEL_SENSE;
          2'd2:    cmd.sel = SEL_ENABLE;
          default: cmd.sel = SEL_NONE;
        endcase
      end
    end else if (int'(region) <= NUM_BANKS && busAddr[11:8] == 4'd0) begin
      cmd.sel  = SEL_VECTOR;
      cmd.bank = 2'(region - 4'd1);
      cmd.slot = busAddr[7:3];
    end
  end
endmodule

// File: rtl/irq_trig_core.sv
module irq_trig_core
  import irq_trig_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int NUM_THREADS = 2,
  localparam int NUM_IRQ    = NUM_BANKS * BANK_SZ
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               busRead,
  input  busCmd_t            cmd,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rdata,
  output logic [NUM_THREADS-1:0] trigN
);
  logic [NUM_IRQ-1:0] syncA, syncB, syncC;
  logic [NUM_IRQ-1:0] statusQ, senseQ, enableQ;
  logic [NUM_IRQ-1:0] toggle, statusD, rise, fall;
  logic [VEC_W-1:0]   vecQ [NUM_IRQ];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign rise = syncB & ~syncC;
  assign fall = ~syncB & syncC;

  always_comb begin
    toggle = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (cmd.wr && cmd.sel == SEL_STATUS && int'(cmd.bank) == b)
        toggle[b*BANK_SZ +: BANK_SZ] = wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (senseQ[i])
        statusD[i] = syncB[i] | ((statusQ[i] ^ toggle[i]) & ~fall[i]);
      else
        statusD[i] = (statusQ[i] ^ toggle[i]) | rise[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      senseQ  <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= statusD;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (cmd.wr && int'(cmd.bank) == b) begin
          if (cmd.sel == SEL_SENSE)  senseQ[b*BANK_SZ +: BANK_SZ]  <= wdata;
          if (cmd.sel == SEL_ENABLE) enableQ[b*BANK_SZ +: BANK_SZ] <= wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IRQ; i++) vecQ[i] <= '0;
    end else if (cmd.wr && cmd.sel == SEL_VECTOR) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (int'({cmd.bank, cmd.slot}) == i) vecQ[i] <= wdata[VEC_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (busRead) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(cmd.bank) == b) begin
          if (cmd.sel == SEL_STATUS) rdata = statusQ[b*BANK_SZ +: BANK_SZ];
          if (cmd.sel == SEL_SENSE)  rdata = senseQ[b*BANK_SZ +: BANK_SZ];
          if (cmd.sel == SEL_ENABLE) rdata = enableQ[b*BANK_SZ +: BANK_SZ];
        end
      end
      if (cmd.sel == SEL_VECTOR) begin
        for (int i = 0; i < NUM_IRQ; i++)
          if (int'({cmd.bank, cmd.slot}) == i)
            rdata = {{(WORD_W-VEC_W){1'b0}}, vecQ[i]};
      end
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : gThread
    logic [NUM_IRQ-1:0] hit;
    always_comb begin
      for (int i = 0; i < NUM_IRQ; i++)
        hit[i] = statusQ[i] & enableQ[i] & (vecQ[i] == VEC_W'(t + 1));
    end
    assign trigN[t] = ~|hit;
  end
endmodule

// File: rtl/irq_trig_router.sv
module irq_trig_router
  import irq_trig_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int NUM_THREADS = 2,
  localparam int NUM_IRQ    = NUM_BANKS * BANK_SZ
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_IRQ-1:0]     irqIn,
  input  logic                   busRead,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [WORD_W-1:0]      busWdata,
  output logic [WORD_W-1:0]      busRdata,
  output logic [NUM_THREADS-1:0] trigN
);
  busCmd_t cmd;

  irq_trig_decode #(.NUM_BANKS(NUM_BANKS)) uDecode (
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .cmd      (cmd)
  );

  irq_trig_core #(.NUM_BANKS(NUM_BANKS), .NUM_THREADS(NUM_THREADS)) uCore (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .busRead (busRead),
    .cmd     (cmd),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .trigN   (trigN)
  );
endmodule

// File: rtl/irq_trig_chk.sv
module irq_trig_chk #(
  parameter int NUM_BANKS   = 2,
  parameter int NUM_THREADS = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busRead,
  input logic                   busWrite,
  input logic [15:0]            busAddr,
  input logic [31:0]            busWdata,
  input logic [31:0]            busRdata,
  input logic [NUM_THREADS-1:0] trigN
);
  function automatic logic bankOk(input logic [15:0] a);
    return a[11:10] == 2'b00 && a[7:5] == 3'b000 && int'(a[4:3]) < NUM_BANKS;
  endfunction

  function automatic logic isWord(input logic [15:0] a, input logic [1:0] kind);
    return a[15:12] == 4'd0 && a[9:8] == kind && bankOk(a);
  endfunction

  function automatic logic isVec(input logic [15:0] a);
    return a[15:12] != 4'd0 && int'(a[15:12]) <= NUM_BANKS && a[11:8] == 4'd0;
  endfunction

  function automatic logic mapped(input logic [15:0] a);
    return isWord(a, 2'd0) || isWord(a, 2'd1) || isWord(a, 2'd2) || isVec(a);
  endfunction

  logic [31:0] enShadow [4];
  logic        anyEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 4; b++) enShadow[b] <= '0;
    end else if (busWrite && isWord(busAddr, 2'd2)) begin
      enShadow[busAddr[4:3]] <= busWdata;
    end
  end

  always_comb begin
    anyEnable = 1'b0;
    for (int b = 0; b < 4; b++) anyEnable = anyEnable | (|enShadow[b]);
  end

  // R1: unmapped addresses read as zero
  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !mapped(busAddr)) |-> busRdata == 32'd0);

  // R3: sensitivity word reads back the value written the cycle before
  assert_sense_readback_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && isWord(busAddr, 2'd1)) |=>
      (!(busRead && busAddr == $past(busAddr)) || busRdata == $past(busWdata)));

  // R7: routing code reads back its low four bits only
  assert_vector_readback_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && isVec(busAddr)) |=>
      (!(busRead && busAddr == $past(busAddr)) ||
       busRdata == {28'd0, $past(busWdata[3:0])}));

  // R9: with no pass bit set anywhere, every trigger stays high
  assert_no_pass_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !anyEnable |-> &trigN);
endmodule

bind irq_trig_router irq_trig_chk #(
  .NUM_BANKS   (NUM_BANKS),
  .NUM_THREADS (NUM_THREADS)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busRead  (busRead),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .trigN    (trigN)
);

// File: tb/irq_trig_router_test.sv
`timescale 1ns/1ps
module irq_trig_router_test;
  localparam int NB = 2;
  localparam int NT = 2;
  localparam int NI = NB * 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NI-1:0] irqIn = '0;
  logic          busRead = 1'b0;
  logic          busWrite = 1'b0;
  logic [15:0]   busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NT-1:0] trigN;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  irq_trig_router #(.NUM_BANKS(NB), .NUM_THREADS(NT)) uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busRead(busRead),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .trigN(trigN)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit [NI-1:0] mStat, mSense, mEn, mS1, mS2, mS3;
  int          mVec [NI];

  // 0 none, 1 pending, 2 sensitivity, 3 pass, 4 routing code (R1 map)
  function automatic int decodeKind(input logic [15:0] a, output int bk, output int sl);
    bk = 0; sl = 0;
    if (a[15:12] == 0) begin
      bk = int'(a[4:3]);
      if (a[11:10] != 0 || a[7:5] != 0 || bk >= NB) return 0;
      case (a[9:8])
        2'd0: return 1;
        2'd1: return 2;
        2'd2: return 3;
        default: return 0;
      endcase
    end
    if (int'(a[15:12]) <= NB && a[11:8] == 0) begin
      bk = int'(a[15:12]) - 1;
      sl = int'(a[7:3]);
      return 4;
    end
    return 0;
  endfunction

  function automatic logic [31:0] modelRead(input logic [15:0] a);
    int bk, sl, k;
    logic [31:0] v;
    k = decodeKind(a, bk, sl);
    v = '0;
    for (int j = 0; j < 32; j++) begin
      if (k == 1) v[j] = mStat[bk*32 + j];
      if (k == 2) v[j] = mSense[bk*32 + j];
      if (k == 3) v[j] = mEn[bk*32 + j];
    end
    if (k == 4) v = 32'(mVec[bk*32 + sl]);
    return v;
  endfunction

  function automatic logic [NT-1:0] modelTrig();
    logic [NT-1:0] r;
    r = '1;
    for (int i = 0; i < NI; i++)
      if (mStat[i] && mEn[i] && mVec[i] >= 1 && mVec[i] <= NT) r[mVec[i]-1] = 1'b0;
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin : modelStep
    bit [NI-1:0] tg;
    int k, bk, sl;
    if (!rstN) begin
      mStat = '0; mSense = '0; mEn = '0; mS1 = '0; mS2 = '0; mS3 = '0;
      for (int i = 0; i < NI; i++) mVec[i] = 0;
    end else begin
      tg = '0;
      k = decodeKind(busAddr, bk, sl);
      if (busWrite && k == 1)
        for (int j = 0; j < 32; j++) tg[bk*32 + j] = busWdata[j];
      for (int i = 0; i < NI; i++) begin
        if (mSense[i]) begin
          if (mS2[i]) mStat[i] = 1'b1;
          else if (mS3[i]) mStat[i] = 1'b0;
          else mStat[i] = mStat[i] ^ tg[i];
        end else begin
          mStat[i] = (mStat[i] ^ tg[i]) | (mS2[i] & ~mS3[i]);
        end
      end
      if (busWrite && k == 2) for (int j = 0; j < 32; j++) mSense[bk*32 + j] = busWdata[j];
      if (busWrite && k == 3) for (int j = 0; j < 32; j++) mEn[bk*32 + j] = busWdata[j];
      if (busWrite && k == 4) mVec[bk*32 + sl] = int'(busWdata[3:0]);
      mS3 = mS2; mS2 = mS1; mS1 = irqIn;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R8 trigger", 32'(trigN), 32'(modelTrig()));
      chk("R1 read data", busRdata, busRead ? modelRead(busAddr) : 32'd0);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busWrite = 1'b1; busRead = 1'b0; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    busRead = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    chk(tag, busRdata, exp);
    @(posedge clk); #1;
    busRead = 1'b0;
  endtask

  task automatic setIrq(input int i, input logic v);
    @(posedge clk); #1;
    irqIn[i] = v;
  endtask

  function automatic logic [15:0] pickAddr();
    int r;
    r = $urandom_range(0, 9);
    if (r < 6) return 16'(($urandom_range(0, 3) << 8) + ($urandom_range(0, 2) << 3));
    if (r < 9) return 16'(($urandom_range(1, 3) << 12) + ($urandom_range(0, 31) << 3));
    return 16'($urandom);
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R2: reset state
    chk("R2 trig after reset", 32'(trigN), 32'h3);
    rd(16'h0000, 0, "R2 pending reset");
    rd(16'h1018, 0, "R2 route reset");

    // R3: sensitivity and pass readback
    wr(16'h0100, 32'h10);
    rd(16'h0100, 32'h10, "R3 sense readback");
    wr(16'h0208, 32'hDEADBEEF);
    rd(16'h0208, 32'hDEADBEEF, "R3 pass readback");
    wr(16'h0208, 32'h0);

    // R7: routing codes
    wr(16'h1018, 1);          // line 3 -> thread 0
    wr(16'h1020, 2);          // line 4 -> thread 1
    wr(16'h1028, 32'hFFFFFFF3);
    rd(16'h1028, 3, "R7 code width");
    wr(16'h1028, 7);          // line 5 unrouted
    rd(16'h1028, 7, "R7 code readback");
    wr(16'h2008, 1);          // line 33 -> thread 0
    wr(16'h0200, 32'h38);     // pass lines 3,4,5

    // R4: edge capture
    setIrq(3, 1); idle(3);
    chk("R4 edge trig", 32'(trigN), 32'h2);
    rd(16'h0000, 32'h8, "R4 edge pending");
    setIrq(3, 0); idle(4);
    rd(16'h0000, 32'h8, "R4 edge held");

    // R6: inverting writes
    wr(16'h0000, 32'h8);
    chk("R6 clear trig", 32'(trigN), 32'h3);
    wr(16'h0000, 32'h0);
    rd(16'h0000, 0, "R6 zero write");
    wr(16'h0000, 32'h8);
    chk("R6 replay trig", 32'(trigN), 32'h2);
    wr(16'h0000, 32'h8);

    // R7: code above thread count is unrouted
    setIrq(5, 1); idle(3);
    chk("R7 unrouted trig", 32'(trigN), 32'h3);
    rd(16'h0000, 32'h20, "R7 unrouted pending");
    setIrq(5, 0);
    wr(16'h0000, 32'h20);

    // R5: level follow
    setIrq(4, 1); idle(3);
    chk("R5 level trig", 32'(trigN), 32'h1);
    wr(16'h0000, 32'h10);
    rd(16'h0000, 32'h10, "R6 level high holds");
    setIrq(4, 0); idle(3);
    chk("R5 level drop trig", 32'(trigN), 32'h3);
    rd(16'h0000, 0, "R5 level drop pending");
    wr(16'h0000, 32'h10);
    rd(16'h0000, 32'h10, "R6 level replay");
    wr(16'h0000, 32'h10);

    // R9: pass bit blocks but pending records
    setIrq(40, 1); idle(3);
    rd(16'h0008, 32'h100, "R9 blocked pending");
    chk("R9 blocked trig", 32'(trigN), 32'h3);
    setIrq(40, 0);
    wr(16'h0008, 32'h100);

    // R1/R8: second bank line
    wr(16'h0208, 32'h2);
    setIrq(33, 1); idle(3);
    rd(16'h0008, 32'h2, "R1 bank1 pending");
    chk("R8 bank1 trig", 32'(trigN), 32'h2);
    setIrq(33, 0);
    wr(16'h0208, 32'h0);
    chk("R9 pass cleared", 32'(trigN), 32'h3);
    wr(16'h0208, 32'h2);
    chk("R8 pass restored", 32'(trigN), 32'h2);
    wr(16'h0008, 32'h2);

    // R1: unmapped space
    wr(16'h0010, 32'hFFFFFFFF);
    rd(16'h0000, 0, "R1 unmapped write b0");
    rd(16'h0008, 0, "R1 unmapped write b1");
    rd(16'h0010, 0, "R1 bank beyond range");
    rd(16'h3000, 0, "R1 route bank beyond range");
    rd(16'h0300, 0, "R1 unused kind");

    // R6: edge lands on the same edge as an inverting write
    wr(16'h0000, 32'h8);
    setIrq(3, 1); idle(1);
    wr(16'h0000, 32'h8);
    rd(16'h0000, 32'h8, "R6 edge beats clear");
    setIrq(3, 0); idle(3);
    wr(16'h0000, 32'h8);
    rd(16'h0000, 0, "R6 cleared after collision");

    // Random phase, judged by the model every cycle
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 5) == 0) irqIn[$urandom_range(0, NI-1)] ^= 1'b1;
      busWrite = ($urandom_range(0, 3) == 0);
      busRead  = !busWrite && ($urandom_range(0, 1) == 1);
      busAddr  = pickAddr();
      busWdata = ($urandom_range(0, 1) == 1) ? $urandom : (32'h1 << $urandom_range(0, 31));
    end
    @(posedge clk); #1;
    busWrite = 1'b0; busRead = 1'b0;
    idle(2);
    finish();
  end
endmodule